// File: doc/BRIEF.md
# Block Port Transfer Engine

This block carries out the block I/O instructions of an 8-bit processor core. It covers the single-step forms and the auto-repeating forms. The core hands over the second opcode byte that follows the ED prefix. It also hands over the current byte counter (register B), the port selector (register C), the 16-bit memory pointer (register pair HL) and the flag byte. The engine then performs one transfer step. It reads a byte from a port and stores it in memory, or it reads a byte from memory and sends it to a port.

Once the step completes, the engine returns the new counter, the new pointer and the new flag byte. It also returns a rewind indication. When rewind is set, the core moves its program counter back by two, so the same instruction is fetched again and the next byte moves.

Every bus access holds its strobe until the addressed side acknowledges. Slow ports and slow memory therefore simply stretch the step.

Top module: `bpt_engine`

## Requirements
- R1: A start pulse is accepted only when the engine is idle and the opcode byte matches the pattern 1 0 1 L D 0 1 X. Bit 4 is L (repeat), bit 3 is D (pointer direction) and bit 0 is X (0 = port to memory, 1 = memory to port). Any other byte is ignored: no strobe, no busy and no done.
- R2: During the port access, the port address is {B, C}, with B taken before it is decremented. The address stays unchanged while the access waits for its acknowledge.
- R3: With X = 0, the engine first reads the port. It then writes the byte it received to memory at the address HL.
- R4: With X = 1, the engine first reads memory at the address HL. It then writes that byte to the port.
- R5: The returned pointer is HL + 1 when D = 0 and HL - 1 when D = 1, wrapping modulo 2^16.
- R6: The returned counter is B - 1. A counter of 0 wraps to 0xFF, so a repeating form started with B = 0 moves 256 bytes.
- R7: In the returned flag byte, bit 1 is always set. Bit 6 is set exactly when the returned counter is zero. All other bits equal the flag byte given at start.
- R8: Rewind is set only when L = 1 and the returned counter is nonzero. A repeating form therefore ends with bit 6 set.
- R9: Only one strobe is active at a time. Each strobe stays high until its acknowledge is sampled high. Done pulses for exactly one cycle, in the cycle after the second access is acknowledged.
- R10: A start pulse that arrives while a step is in progress is ignored. The step in progress completes with its original operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request one transfer step |
| opcode_i | input | 8 | Opcode byte following the prefix |
| cnt_i | input | 8 | Byte counter (B) |
| sel_i | input | 8 | Port selector (C) |
| ptr_i | input | 16 | Memory pointer (HL) |
| flags_i | input | 8 | Flag byte before the step |
| port_addr_o | output | 16 | Port address {B, C} |
| port_rd_o | output | 1 | Port read strobe |
| port_wr_o | output | 1 | Port write strobe |
| port_wdata_o | output | 8 | Byte sent to the port |
| port_rdata_i | input | 8 | Byte returned by the port |
| port_ack_i | input | 1 | Port access acknowledge |
| mem_addr_o | output | 16 | Memory address (HL) |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 8 | Byte written to memory |
| mem_rdata_i | input | 8 | Byte returned by memory |
| mem_ack_i | input | 1 | Memory access acknowledge |
| busy_o | output | 1 | Step in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cnt_o | output | 8 | Updated counter |
| ptr_o | output | 16 | Updated pointer |
| flags_o | output | 8 | Updated flag byte |
| rewind_o | output | 1 | Move the program counter back by two |

## Verification
The assertions check, on every cycle, the following properties:
- at most one strobe is active;
- each strobe and the port address hold steady until acknowledged;
- no strobe is active while the engine is idle;
- done lasts a single cycle and directly follows an acknowledge;
- the zero and subtract flag bits, and the rewind output, agree with the returned counter.

Only the directed scenarios can show the rest. These cover:
- the data path in both directions;
- the direction of the pointer step;
- the wrap of the counter from zero through a 256-byte repeat;
- the number of repetitions a repeating form performs;
- that unmatched opcodes and starts issued while busy leave the buses untouched.

// File: rtl/bpt_pkg.sv
package bpt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SRC  = 2'd1,
        ST_DST  = 2'd2
    } bpt_state_e;

    typedef struct packed {
        logic again;    // repeat while counter nonzero
        logic down;     // pointer steps downward
        logic to_port;  // memory -> port when set
    } bpt_mode_t;

endpackage

// File: rtl/bpt_decode.sv
module bpt_decode
    import bpt_pkg::*;
#(
    parameter int OP_W      = 8,
    parameter int AGAIN_BIT = 4,
    parameter int DOWN_BIT  = 3,
    parameter int DIR_BIT   = 0
) (
    input  logic [OP_W-1:0] opcode,
    output logic            valid,
    output bpt_mode_t       mode
);
    localparam logic [OP_W-1:0] FIXED_MASK  = OP_W'(8'hE6);
    localparam logic [OP_W-1:0] FIXED_VALUE = OP_W'(8'hA2);

    always_comb begin
        valid        = (opcode & FIXED_MASK) == FIXED_VALUE;
        mode.again   = opcode[AGAIN_BIT];
        mode.down    = opcode[DOWN_BIT];
        mode.to_port = opcode[DIR_BIT];
    end
endmodule

// File: rtl/bpt_step_math.sv
module bpt_step_math #(
    parameter int DATA_W = 8,
    parameter int Z_BIT  = 6,
    parameter int N_BIT  = 1
) (
    input  logic [DATA_W-1:0]   cnt,
    input  logic [2*DATA_W-1:0] ptr,
    input  logic [DATA_W-1:0]   flags,
    input  logic                down,
    input  logic                again,
    output logic [DATA_W-1:0]   cnt_next,
    output logic [2*DATA_W-1:0] ptr_next,
    output logic [DATA_W-1:0]   flags_next,
    output logic                rewind
);
    localparam int WORD_W = 2 * DATA_W;

    logic cnt_zero;

    always_comb begin
        cnt_next = cnt - DATA_W'(1);
        cnt_zero = (cnt_next == '0);
        ptr_next = down ? (ptr - WORD_W'(1)) : (ptr + WORD_W'(1));
        rewind   = again && !cnt_zero;
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_flag
        if (i == Z_BIT) begin : g_zero
            assign flags_next[i] = cnt_zero;
        end else if (i == N_BIT) begin : g_sub
            assign flags_next[i] = 1'b1;
        end else begin : g_keep
            assign flags_next[i] = flags[i];
        end
    end
endmodule

// File: rtl/bpt_engine.sv
module bpt_engine
    import bpt_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int Z_BIT  = 6,
    parameter int N_BIT  = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [7:0]           opcode_i,
    input  logic [DATA_W-1:0]    cnt_i,
    input  logic [DATA_W-1:0]    sel_i,
    input  logic [2*DATA_W-1:0]  ptr_i,
    input  logic [DATA_W-1:0]    flags_i,
    output logic [2*DATA_W-1:0]  port_addr_o,
    output logic                 port_rd_o,
    output logic                 port_wr_o,
    output logic [DATA_W-1:0]    port_wdata_o,
    input  logic [DATA_W-1:0]    port_rdata_i,
    input  logic                 port_ack_i,
    output logic [2*DATA_W-1:0]  mem_addr_o,
    output logic                 mem_rd_o,
    output logic                 mem_wr_o,
    output logic [DATA_W-1:0]    mem_wdata_o,
    input  logic [DATA_W-1:0]    mem_rdata_i,
    input  logic                 mem_ack_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [DATA_W-1:0]    cnt_o,
    output logic [2*DATA_W-1:0]  ptr_o,
    output logic [DATA_W-1:0]    flags_o,
    output logic                 rewind_o
);
    localparam int WORD_W = 2 * DATA_W;

    typedef struct packed {
        bpt_state_e        st;
        bpt_mode_t         mode;
        logic [DATA_W-1:0] cnt;
        logic [DATA_W-1:0] sel;
        logic [WORD_W-1:0] ptr;
        logic [DATA_W-1:0] flg;
        logic [DATA_W-1:0] data;
        logic              done;
        logic              rewind;
        logic [DATA_W-1:0] cnt_res;
        logic [WORD_W-1:0] ptr_res;
        logic [DATA_W-1:0] flg_res;
    } regs_t;

    regs_t r_q, r_d;

    logic              op_valid;
    bpt_mode_t         op_mode;
    logic [DATA_W-1:0] cnt_nx;
    logic [WORD_W-1:0] ptr_nx;
    logic [DATA_W-1:0] flg_nx;
    logic              rew_nx;
    logic              src_ack;
    logic              dst_ack;
    logic [DATA_W-1:0] src_data;

    bpt_decode u_decode (
        .opcode (opcode_i),
        .valid  (op_valid),
        .mode   (op_mode)
    );

    bpt_step_math #(
        .DATA_W (DATA_W),
        .Z_BIT  (Z_BIT),
        .N_BIT  (N_BIT)
    ) u_math (
        .cnt        (r_q.cnt),
        .ptr        (r_q.ptr),
        .flags      (r_q.flg),
        .down       (r_q.mode.down),
        .again      (r_q.mode.again),
        .cnt_next   (cnt_nx),
        .ptr_next   (ptr_nx),
        .flags_next (flg_nx),
        .rewind     (rew_nx)
    );

    // Source side is the port for input steps, memory for output steps.
    always_comb begin
        src_ack  = r_q.mode.to_port ? mem_ack_i   : port_ack_i;
        dst_ack  = r_q.mode.to_port ? port_ack_i  : mem_ack_i;
        src_data = r_q.mode.to_port ? mem_rdata_i : port_rdata_i;
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i && op_valid) begin
                    r_d.st   = ST_SRC;
                    r_d.mode = op_mode;
                    r_d.cnt  = cnt_i;
                    r_d.sel  = sel_i;
                    r_d.ptr  = ptr_i;
                    r_d.flg  = flags_i;
                end
            end
            ST_SRC: begin
                if (src_ack) begin
                    r_d.data = src_data;
                    r_d.st   = ST_DST;
                end
            end
            ST_DST: begin
                if (dst_ack) begin
                    r_d.st      = ST_IDLE;
                    r_d.done    = 1'b1;
                    r_d.cnt_res = cnt_nx;
                    r_d.ptr_res = ptr_nx;
                    r_d.flg_res = flg_nx;
                    r_d.rewind  = rew_nx;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        port_rd_o    = (r_q.st == ST_SRC) && !r_q.mode.to_port;
        mem_rd_o     = (r_q.st == ST_SRC) &&  r_q.mode.to_port;
        mem_wr_o     = (r_q.st == ST_DST) && !r_q.mode.to_port;
        port_wr_o    = (r_q.st == ST_DST) &&  r_q.mode.to_port;
        port_addr_o  = {r_q.cnt, r_q.sel};
        mem_addr_o   = r_q.ptr;
        port_wdata_o = r_q.data;
        mem_wdata_o  = r_q.data;
        busy_o       = (r_q.st != ST_IDLE);
        done_o       = r_q.done;
        cnt_o        = r_q.cnt_res;
        ptr_o        = r_q.ptr_res;
        flags_o      = r_q.flg_res;
        rewind_o     = r_q.rewind;
    end
endmodule

// File: rtl/bpt_engine_checker.sv
module bpt_engine_checker #(
    parameter int DATA_W = 8,
    parameter int Z_BIT  = 6,
    parameter int N_BIT  = 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2*DATA_W-1:0] port_addr_o,
    input logic                port_rd_o,
    input logic                port_wr_o,
    input logic                port_ack_i,
    input logic                mem_rd_o,
    input logic                mem_wr_o,
    input logic                mem_ack_i,
    input logic                busy_o,
    input logic                done_o,
    input logic [DATA_W-1:0]   cnt_o,
    input logic [DATA_W-1:0]   flags_o,
    input logic                rewind_o
);
    a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({port_rd_o, port_wr_o, mem_rd_o, mem_wr_o}));

    a_r9_port_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        port_rd_o && !port_ack_i |=> port_rd_o);

    a_r9_port_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr_o && !port_ack_i |=> port_wr_o);

    a_r9_mem_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o && !mem_ack_i |=> mem_rd_o);

    a_r9_mem_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o && !mem_ack_i |=> mem_wr_o);

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r9_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(port_ack_i || mem_ack_i));

    a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd_o || port_wr_o) && !port_ack_i |=> $stable(port_addr_o));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !(port_rd_o || port_wr_o || mem_rd_o || mem_wr_o));

    a_r7_flag_bits: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> flags_o[N_BIT] && (flags_o[Z_BIT] == (cnt_o == '0)));

    a_r8_rewind_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        rewind_o |-> cnt_o != '0);
endmodule

bind bpt_engine bpt_engine_checker #(
    .DATA_W (DATA_W),
    .Z_BIT  (Z_BIT),
    .N_BIT  (N_BIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .port_addr_o (port_addr_o),
    .port_rd_o   (port_rd_o),
    .port_wr_o   (port_wr_o),
    .port_ack_i  (port_ack_i),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .mem_ack_i   (mem_ack_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .cnt_o       (cnt_o),
    .flags_o     (flags_o),
    .rewind_o    (rewind_o)
);

// File: tb/bpt_engine_test.sv
module bpt_engine_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  opcode_i = '0;
    logic [7:0]  cnt_i = '0;
    logic [7:0]  sel_i = '0;
    logic [15:0] ptr_i = '0;
    logic [7:0]  flags_i = '0;
    logic [15:0] port_addr_o;
    logic        port_rd_o, port_wr_o;
    logic [7:0]  port_wdata_o;
    logic [7:0]  port_rdata_i = '0;
    logic        port_ack_i = 1'b0;
    logic [15:0] mem_addr_o;
    logic        mem_rd_o, mem_wr_o;
    logic [7:0]  mem_wdata_o;
    logic [7:0]  mem_rdata_i = '0;
    logic        mem_ack_i = 1'b0;
    logic        busy_o, done_o, rewind_o;
    logic [7:0]  cnt_o, flags_o;
    logic [15:0] ptr_o;

    int checks = 0;
    int errors = 0;
    int lat = 0;
    int pw = 0;
    int mw = 0;
    int port_acks = 0;
    int mem_acks = 0;
    logic [15:0] last_paddr = '0;
    logic [7:0]  last_pwdata = '0;
    logic        last_pwrite = 1'b0;
    logic [15:0] last_maddr = '0;
    logic        last_mwrite = 1'b0;
    logic [7:0]  mem [0:255];

    always #(CLK_PERIOD/2) clk = ~clk;

    bpt_engine uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
        .cnt_i(cnt_i), .sel_i(sel_i), .ptr_i(ptr_i), .flags_i(flags_i),
        .port_addr_o(port_addr_o), .port_rd_o(port_rd_o), .port_wr_o(port_wr_o),
        .port_wdata_o(port_wdata_o), .port_rdata_i(port_rdata_i), .port_ack_i(port_ack_i),
        .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i),
        .busy_o(busy_o), .done_o(done_o), .cnt_o(cnt_o), .ptr_o(ptr_o),
        .flags_o(flags_o), .rewind_o(rewind_o)
    );

    function automatic logic [7:0] pval(input logic [15:0] a);
        return a[15:8] ^ a[7:0] ^ 8'h3C;
    endfunction

    function automatic logic [7:0] exp_flags(input logic [7:0] f, input logic [7:0] b);
        return (f & 8'hBF) | ((b == 8'h00) ? 8'h40 : 8'h00) | 8'h02;
    endfunction

    // Port responder: acknowledges after lat waiting cycles.
    always @(negedge clk) begin
        if (!rst_n) begin
            port_ack_i = 1'b0; pw = 0;
        end else if (port_ack_i) begin
            port_ack_i = 1'b0; pw = 0;
        end else if (port_rd_o || port_wr_o) begin
            if (pw >= lat) begin
                port_ack_i   = 1'b1;
                port_acks    = port_acks + 1;
                last_paddr   = port_addr_o;
                last_pwrite  = port_wr_o;
                last_pwdata  = port_wdata_o;
                port_rdata_i = pval(port_addr_o);
            end else begin
                pw = pw + 1;
            end
        end
    end

    // Memory responder, 256 bytes indexed by the low address byte.
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack_i = 1'b0; mw = 0;
            for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        end else if (mem_ack_i) begin
            mem_ack_i = 1'b0; mw = 0;
        end else if (mem_rd_o || mem_wr_o) begin
            if (mw >= lat) begin
                mem_ack_i   = 1'b1;
                mem_acks    = mem_acks + 1;
                last_maddr  = mem_addr_o;
                last_mwrite = mem_wr_o;
                if (mem_wr_o) mem[mem_addr_o[7:0]] = mem_wdata_o;
                mem_rdata_i = mem[mem_addr_o[7:0]];
            end else begin
                mw = mw + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [7:0] op, input logic [7:0] b,
                               input logic [7:0] c, input logic [15:0] hl,
                               input logic [7:0] f);
        @(negedge clk);
        opcode_i = op; cnt_i = b; sel_i = c; ptr_i = hl; flags_i = f;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        int n = 0;
        while (!done_o && n < 200) begin
            @(negedge clk);
            n++;
        end
        seen = done_o;
    endtask

    // One step with full result checks for a single form.
    task automatic t_single(input logic [7:0] op, input logic [7:0] b, input logic [7:0] c,
                            input logic [15:0] hl, input logic [7:0] f, input string tag);
        bit seen;
        int pa0 = port_acks, ma0 = mem_acks;
        logic [7:0]  eb  = b - 8'd1;
        logic [15:0] ehl = op[3] ? hl - 16'd1 : hl + 16'd1;
        logic [7:0]  mem_before = mem[hl[7:0]];
        pulse_start(op, b, c, hl, f);
        wait_done(seen);
        check(seen, {tag, " R9 done seen"}, seen, 1);
        check(port_acks - pa0 == 1 && mem_acks - ma0 == 1, {tag, " R9 one access each"},
              port_acks - pa0 + mem_acks - ma0, 2);
        check(last_paddr == {b, c}, {tag, " R2 port address"}, last_paddr, {b, c});
        check(last_maddr == hl, {tag, " R3/R4 memory address"}, last_maddr, hl);
        if (op[0] == 1'b0) begin
            check(!last_pwrite && last_mwrite && mem[hl[7:0]] == pval({b, c}),
                  {tag, " R3 port byte stored"}, mem[hl[7:0]], pval({b, c}));
        end else begin
            check(last_pwrite && !last_mwrite && last_pwdata == mem_before,
                  {tag, " R4 memory byte sent"}, last_pwdata, mem_before);
        end
        check(cnt_o == eb, {tag, " R6 counter"}, cnt_o, eb);
        check(ptr_o == ehl, {tag, " R5 pointer"}, ptr_o, ehl);
        check(flags_o == exp_flags(f, eb), {tag, " R7 flags"}, flags_o, exp_flags(f, eb));
        check(rewind_o == (op[4] && eb != 0), {tag, " R8 rewind"}, rewind_o, op[4] && eb != 0);
        @(negedge clk);
        check(!done_o, {tag, " R9 done one cycle"}, done_o, 0);
    endtask

    // Repeating form, fed back the way a rewound instruction would be.
    task automatic t_repeat(input logic [7:0] op, input logic [7:0] b0, input logic [15:0] hl0,
                            input string tag);
        logic [7:0]  b = b0;
        logic [15:0] hl = hl0;
        int iters = 0;
        int bad = 0;
        int expect_iters = (b0 == 8'h00) ? 256 : int'(b0);
        bit seen;
        logic [7:0] pre;
        forever begin
            pre = mem[hl[7:0]];
            pulse_start(op, b, 8'h21, hl, 8'h00);
            wait_done(seen);
            iters++;
            if (!seen) begin bad++; break; end
            if (op[0] && last_pwdata != pre) bad++;
            if (!op[0] && mem[hl[7:0]] != pval({b, 8'h21})) bad++;
            if (cnt_o != b - 8'd1) bad++;
            if (ptr_o != (op[3] ? hl - 16'd1 : hl + 16'd1)) bad++;
            if (rewind_o != (cnt_o != 8'h00)) bad++;
            if (!rewind_o || iters > 300) break;
            b = cnt_o; hl = ptr_o;
        end
        check(bad == 0, {tag, " R3/R4/R5/R6 per-step data"}, bad, 0);
        check(iters == expect_iters, {tag, " R8 repetition count"}, iters, expect_iters);
        check(cnt_o == 8'h00 && flags_o == 8'h42, {tag, " R7 final flags"}, flags_o, 8'h42);
    endtask

    task automatic t_reset();
        check(!busy_o && !done_o && !rewind_o, "R9 reset idle", {busy_o, done_o, rewind_o}, 0);
        check(!(port_rd_o | port_wr_o | mem_rd_o | mem_wr_o), "R9 reset no strobe",
              {port_rd_o, port_wr_o, mem_rd_o, mem_wr_o}, 0);
        check(cnt_o == 0 && ptr_o == 0 && flags_o == 0, "R7 reset results", flags_o, 0);
    endtask

    task automatic t_bad_opcode(input logic [7:0] op);
        int pa0 = port_acks, ma0 = mem_acks;
        int busy_seen = 0;
        pulse_start(op, 8'h05, 8'h10, 16'h0030, 8'h00);
        for (int i = 0; i < 6; i++) begin
            if (busy_o || done_o) busy_seen++;
            @(negedge clk);
        end
        check(busy_seen == 0 && port_acks == pa0 && mem_acks == ma0, "R1 unmatched opcode ignored",
              busy_seen + port_acks - pa0 + mem_acks - ma0, 0);
    endtask

    task automatic t_busy_start();
        bit seen;
        int pa0 = port_acks, ma0 = mem_acks;
        pulse_start(8'hA2, 8'h09, 8'h44, 16'h0080, 8'h81);
        // second request while busy, different operands
        opcode_i = 8'hAB; cnt_i = 8'h01; sel_i = 8'h99; ptr_i = 16'h00F0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done(seen);
        check(cnt_o == 8'h08 && ptr_o == 16'h0081, "R10 original operands kept", ptr_o, 16'h0081);
        for (int i = 0; i < 6; i++) @(negedge clk);
        check(!busy_o && port_acks - pa0 == 1 && mem_acks - ma0 == 1, "R10 second start ignored",
              port_acks - pa0 + mem_acks - ma0, 2);
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single(8'hA2, 8'h03, 8'h10, 16'h0040, 8'hA5, "input-inc");
        t_single(8'hAA, 8'h07, 8'h5E, 16'h1250, 8'hFF, "input-dec");
        t_single(8'hA3, 8'h02, 8'h33, 16'h0020, 8'h00, "output-inc");
        t_single(8'hAB, 8'h01, 8'h77, 16'h0000, 8'h3C, "output-dec-wrap");
        t_single(8'hA2, 8'h00, 8'h01, 16'hFFFF, 8'h40, "input-b0-wrap");
        t_single(8'hB2, 8'h01, 8'h02, 16'h0010, 8'h00, "repeat-last");
        lat = 3;
        t_single(8'hA3, 8'h10, 8'hC0, 16'h0066, 8'h11, "output-wait");
        lat = 0;
        t_bad_opcode(8'hA0);
        t_bad_opcode(8'hA6);
        t_bad_opcode(8'hE2);
        t_busy_start();
        t_repeat(8'hB2, 8'h05, 16'h0090, "input-repeat");
        t_repeat(8'hBB, 8'h00, 16'h00FF, "output-repeat-256");
        lat = 1;
        t_repeat(8'hBA, 8'h04, 16'h0003, "input-repeat-dec");
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                checks = checks + 1;
                errors = errors + 1;
                $display("FAIL watchdog R9 actual=%0h expected=%0h", 1, 0);
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule